// File: doc/BRIEF.md
# DRAM Bank Access Latency Estimator

This block predicts how long one DRAM request will take, given the recorded state of the bank the request targets. The request supplies its row and its arrival time. The bank state supplies four values: the row currently open (or a marker meaning no row is open), the time until which the bank is busy, the earliest time the open row may be closed, and the earliest time a new row may be activated. Three timing parameters are also inputs: the precharge time (tRP), the activate-to-column time (tRCD) and the column access time (tCL).

The estimator returns three results. The first is the total access latency measured from arrival. The second is the part of that latency spent on bank operations alone. The third is a flag that reports whether the request hits the open row. A scheduler pulses `in_valid` with a complete set of operands. One clock later it reads the results, which come with `out_valid`. The results keep their values until the next request. Each request is computed independently, and the block holds no bank history of its own.

Control is a two-state machine. `ST_IDLE` means no fresh result is present. `ST_RESULT` means the registered outputs were loaded on the previous edge. There are three transitions. `go_result` moves from `ST_IDLE` to `ST_RESULT` on `in_valid`. `stay_result` stays in `ST_RESULT` on a back-to-back `in_valid`. `drop_result` moves from `ST_RESULT` to `ST_IDLE` when `in_valid` is low.

Top module: `dlat_estimator`

## Requirements
- R1: All times are unsigned TIME_W-bit tick counts, and every comparison between times is unsigned. The all-ones value of a row field is reserved to mean "no open row". A request is a row hit when `in_req_row` equals `in_open_row` and `in_open_row` is not all-ones. `out_row_hit` reports this.
- R2: On a row hit where `in_busy_until` is strictly greater than `in_arrival`, the total latency is `in_busy_until - in_arrival` and the bank latency is 0.
- R3: On a row hit where `in_busy_until` is less than or equal to `in_arrival`, both the total latency and the bank latency equal `in_t_cl`. On a hit, `in_ras_done` and `in_act_allowed` have no effect on either latency.
- R4: On a miss, let L be the larger of `in_busy_until` and `in_ras_done`. The miss first waits W = L - `in_arrival` when L is greater than `in_arrival`, and W = 0 otherwise.
- R5: On a miss, the precharge delay P is 0 when `in_open_row` is all-ones, and `in_t_rp` otherwise.
- R6: On a miss, the candidate activate time is C = `in_arrival` + W + P. When C is strictly less than `in_act_allowed`, the total latency gains an extra `in_act_allowed - C`. Otherwise there is no extra stall.
- R7: On a miss, the bank latency is P + `in_t_rcd` + `in_t_cl`. The total latency is W + the stall from R6 + P + `in_t_rcd` + `in_t_cl`.
- R8: The results are registered. `out_valid` is high in exactly the cycle after each cycle in which `in_valid` is sampled high, and low otherwise. The result outputs change only on an edge where `in_valid` is high.
- R9: While reset is asserted, and after it until the first request, `out_valid`, `out_row_hit`, `out_total_lat` and `out_bank_lat` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid this cycle |
| in_req_row | input | ROW_W | Row addressed by the request |
| in_arrival | input | TIME_W | Arrival time of the request |
| in_open_row | input | ROW_W | Row open in the bank, all-ones when none |
| in_busy_until | input | TIME_W | Time until which the bank is busy |
| in_ras_done | input | TIME_W | Earliest time the open row may be closed |
| in_act_allowed | input | TIME_W | Earliest time an activate may issue |
| in_t_rp | input | TIME_W | Precharge time |
| in_t_rcd | input | TIME_W | Activate-to-column time |
| in_t_cl | input | TIME_W | Column access time |
| out_valid | output | 1 | Results below are fresh this cycle |
| out_row_hit | output | 1 | Request hit the open row |
| out_total_lat | output | TIME_W | Total latency from arrival |
| out_bank_lat | output | TIME_W | Bank-operation part of the latency |

## Verification
The stimulus covers four kinds of request. Hits against a busy bank and hits against an idle bank separate the remaining-busy-time result from the column-time-only result. Misses with no open row and misses with an open row show whether the precharge term is included. Misses whose row-close or activate bounds lie beyond arrival show whether the close wait and the activate stall are counted. Directed cases place the busy time exactly at arrival and the candidate activate time exactly at the activate bound, which checks the strict-inequality edges. Other directed cases present a hit with a late row-close bound, to show that bound is ignored, and an all-ones request row with no open row, to show the sentinel is not taken as a hit. Random operands with a fixed seed then mix all of these cases.

// File: rtl/dlat_pkg.sv
package dlat_pkg;

    parameter int DLAT_TIME_W = 32;
    parameter int DLAT_ROW_W  = 16;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } dlat_state_e;

endpackage

// File: rtl/dlat_hit_path.sv
module dlat_hit_path #(
    parameter int TIME_W = 32
) (
    input  logic [TIME_W-1:0] arrival,
    input  logic [TIME_W-1:0] busy_until,
    input  logic [TIME_W-1:0] t_cl,
    output logic [TIME_W-1:0] total_lat,
    output logic [TIME_W-1:0] bank_lat
);

    logic still_busy;

    always_comb begin
        still_busy = busy_until > arrival;
        if (still_busy) begin
            // ride on the in-flight access: no extra bank work
            total_lat = busy_until - arrival;
            bank_lat  = '0;
        end else begin
            total_lat = t_cl;
            bank_lat  = t_cl;
        end
    end

endmodule

// File: rtl/dlat_miss_path.sv
module dlat_miss_path #(
    parameter int TIME_W = 32
) (
    input  logic              no_open_row,
    input  logic [TIME_W-1:0] arrival,
    input  logic [TIME_W-1:0] busy_until,
    input  logic [TIME_W-1:0] ras_done,
    input  logic [TIME_W-1:0] act_allowed,
    input  logic [TIME_W-1:0] t_rp,
    input  logic [TIME_W-1:0] t_rcd,
    input  logic [TIME_W-1:0] t_cl,
    output logic [TIME_W-1:0] total_lat,
    output logic [TIME_W-1:0] bank_lat
);

    logic [TIME_W-1:0] close_bound;
    logic [TIME_W-1:0] close_wait;
    logic [TIME_W-1:0] pre_delay;
    logic [TIME_W-1:0] act_cand;
    logic [TIME_W-1:0] act_stall;
    logic [TIME_W-1:0] fixed_part;

    always_comb begin
        close_bound = (busy_until > ras_done) ? busy_until : ras_done;
        close_wait  = (close_bound > arrival) ? (close_bound - arrival) : '0;
        pre_delay   = no_open_row ? '0 : t_rp;
        act_cand    = arrival + close_wait + pre_delay;
        act_stall   = (act_cand < act_allowed) ? (act_allowed - act_cand) : '0;
        fixed_part  = pre_delay + t_rcd + t_cl;
        total_lat   = close_wait + act_stall + fixed_part;
        bank_lat    = fixed_part;
    end

endmodule

// File: rtl/dlat_estimator.sv
module dlat_estimator
    import dlat_pkg::*;
#(
    parameter int TIME_W = DLAT_TIME_W,
    parameter int ROW_W  = DLAT_ROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ROW_W-1:0]  in_req_row,
    input  logic [TIME_W-1:0] in_arrival,
    input  logic [ROW_W-1:0]  in_open_row,
    input  logic [TIME_W-1:0] in_busy_until,
    input  logic [TIME_W-1:0] in_ras_done,
    input  logic [TIME_W-1:0] in_act_allowed,
    input  logic [TIME_W-1:0] in_t_rp,
    input  logic [TIME_W-1:0] in_t_rcd,
    input  logic [TIME_W-1:0] in_t_cl,
    output logic              out_valid,
    output logic              out_row_hit,
    output logic [TIME_W-1:0] out_total_lat,
    output logic [TIME_W-1:0] out_bank_lat
);

    localparam logic [ROW_W-1:0] NO_ROW = {ROW_W{1'b1}};

    dlat_state_e state_q, state_d;

    logic              bank_idle;
    logic              hit;
    logic [TIME_W-1:0] hit_total, hit_bank;
    logic [TIME_W-1:0] miss_total, miss_bank;
    logic [TIME_W-1:0] sel_total, sel_bank;

    assign bank_idle = (in_open_row == NO_ROW);
    assign hit       = !bank_idle && (in_req_row == in_open_row);

    dlat_hit_path #(.TIME_W(TIME_W)) hit_u (
        .arrival    (in_arrival),
        .busy_until (in_busy_until),
        .t_cl       (in_t_cl),
        .total_lat  (hit_total),
        .bank_lat   (hit_bank)
    );

    dlat_miss_path #(.TIME_W(TIME_W)) miss_u (
        .no_open_row (bank_idle),
        .arrival     (in_arrival),
        .busy_until  (in_busy_until),
        .ras_done    (in_ras_done),
        .act_allowed (in_act_allowed),
        .t_rp        (in_t_rp),
        .t_rcd       (in_t_rcd),
        .t_cl        (in_t_cl),
        .total_lat   (miss_total),
        .bank_lat    (miss_bank)
    );

    assign sel_total = hit ? hit_total : miss_total;
    assign sel_bank  = hit ? hit_bank  : miss_bank;

    // next-state: go_result / stay_result / drop_result
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_row_hit   <= 1'b0;
            out_total_lat <= '0;
            out_bank_lat  <= '0;
        end else if (in_valid) begin
            out_row_hit   <= hit;
            out_total_lat <= sel_total;
            out_bank_lat  <= sel_bank;
        end
    end

    assign out_valid = (state_q == ST_RESULT);

endmodule

// File: rtl/dlat_estimator_chk.sv
module dlat_estimator_chk #(
    parameter int TIME_W = 32,
    parameter int ROW_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [TIME_W-1:0] in_t_rp,
    input logic [TIME_W-1:0] in_t_rcd,
    input logic [TIME_W-1:0] in_t_cl,
    input logic              out_valid,
    input logic              out_row_hit,
    input logic [TIME_W-1:0] out_total_lat,
    input logic [TIME_W-1:0] out_bank_lat
);

    // R8
    result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_total_lat) && $stable(out_bank_lat) && $stable(out_row_hit)));

    // R2 R3
    hit_bank_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_row_hit) |-> (out_bank_lat == '0 || out_bank_lat == $past(in_t_cl)));

    // R5 R7
    miss_bank_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_row_hit) |->
            (out_bank_lat == TIME_W'($past(in_t_rcd) + $past(in_t_cl)) ||
             out_bank_lat == TIME_W'($past(in_t_rp) + $past(in_t_rcd) + $past(in_t_cl))));

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && out_total_lat == '0 && out_bank_lat == '0));

endmodule

bind dlat_estimator dlat_estimator_chk #(.TIME_W(TIME_W), .ROW_W(ROW_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_t_rp       (in_t_rp),
    .in_t_rcd      (in_t_rcd),
    .in_t_cl       (in_t_cl),
    .out_valid     (out_valid),
    .out_row_hit   (out_row_hit),
    .out_total_lat (out_total_lat),
    .out_bank_lat  (out_bank_lat)
);

// File: tb/dlat_estimator_tb_top.sv
module dlat_estimator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 32;
    localparam int RW = 16;
    localparam logic [RW-1:0] NONE = {RW{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [RW-1:0] in_req_row = '0;
    logic [TW-1:0] in_arrival = '0;
    logic [RW-1:0] in_open_row = '0;
    logic [TW-1:0] in_busy_until = '0;
    logic [TW-1:0] in_ras_done = '0;
    logic [TW-1:0] in_act_allowed = '0;
    logic [TW-1:0] in_t_rp = '0;
    logic [TW-1:0] in_t_rcd = '0;
    logic [TW-1:0] in_t_cl = '0;
    logic          out_valid;
    logic          out_row_hit;
    logic [TW-1:0] out_total_lat;
    logic [TW-1:0] out_bank_lat;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dlat_estimator #(.TIME_W(TW), .ROW_W(RW)) dut_i (
        .clk, .rst_n, .in_valid, .in_req_row, .in_arrival, .in_open_row,
        .in_busy_until, .in_ras_done, .in_act_allowed, .in_t_rp, .in_t_rcd,
        .in_t_cl, .out_valid, .out_row_hit, .out_total_lat, .out_bank_lat
    );

    task automatic chk(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // model: returns {hit, total, bank}
    function automatic void model(input logic [RW-1:0] rr, input logic [TW-1:0] arr,
                                  input logic [RW-1:0] orow, input logic [TW-1:0] busy,
                                  input logic [TW-1:0] ras, input logic [TW-1:0] act,
                                  input logic [TW-1:0] rp, input logic [TW-1:0] rcd,
                                  input logic [TW-1:0] cl,
                                  output bit hit, output longint tot, output longint bnk);
        longint w, p, c, s, l;
        hit = (orow != NONE) && (rr == orow);
        if (hit) begin
            if (busy > arr) begin tot = busy - arr; bnk = 0; end
            else begin tot = cl; bnk = cl; end
        end else begin
            l = (busy > ras) ? busy : ras;
            w = (l > arr) ? l - arr : 0;
            p = (orow == NONE) ? 0 : rp;
            c = arr + w + p;
            s = (c < act) ? act - c : 0;
            bnk = p + rcd + cl;
            tot = w + s + bnk;
        end
    endfunction

    task automatic run_one(string tag, logic [RW-1:0] rr, logic [TW-1:0] arr,
                           logic [RW-1:0] orow, logic [TW-1:0] busy, logic [TW-1:0] ras,
                           logic [TW-1:0] act, logic [TW-1:0] rp, logic [TW-1:0] rcd,
                           logic [TW-1:0] cl);
        bit eh; longint et, eb;
        logic [TW-1:0] held;
        model(rr, arr, orow, busy, ras, act, rp, rcd, cl, eh, et, eb);
        @(negedge clk);
        in_req_row = rr; in_arrival = arr; in_open_row = orow; in_busy_until = busy;
        in_ras_done = ras; in_act_allowed = act; in_t_rp = rp; in_t_rcd = rcd; in_t_cl = cl;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R8 valid"}, out_valid, 1);
        chk({tag, " R1 hit"}, out_row_hit, eh);
        chk({tag, " total"}, out_total_lat, et);
        chk({tag, " bank"}, out_bank_lat, eb);
        held = out_total_lat;
        // scramble operands while idle: outputs must hold (R8)
        in_arrival = in_arrival + 32'd77; in_t_cl = in_t_cl + 32'd5;
        @(negedge clk);
        chk({tag, " R8 drop"}, out_valid, 0);
        chk({tag, " R8 hold"}, out_total_lat, held);
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        #(CLK_PERIOD * 2);
        @(negedge clk);
        // R9 reset state
        chk("R9 valid", out_valid, 0);
        chk("R9 total", out_total_lat, 0);
        chk("R9 bank", out_bank_lat, 0);
        chk("R9 hit", out_row_hit, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", out_valid, 0);

        // R2 hit, bank busy
        run_one("R2 hit busy", 16'd5, 32'd100, 16'd5, 32'd130, 32'd900, 32'd900, 32'd11, 32'd13, 32'd14);
        // R3 hit, busy == arrival (not strictly later)
        run_one("R3 hit edge", 16'd5, 32'd100, 16'd5, 32'd100, 32'd500, 32'd700, 32'd11, 32'd13, 32'd14);
        // R3 hit idle, late ras/act ignored
        run_one("R3 hit idle", 16'd9, 32'd400, 16'd9, 32'd10, 32'd9000, 32'd9000, 32'd11, 32'd13, 32'd14);
        // R1 R5 sentinel row, nothing open: miss without precharge
        run_one("R1 R5 sentinel", NONE, 32'd200, NONE, 32'd0, 32'd0, 32'd0, 32'd11, 32'd13, 32'd14);
        // R4 miss, ras_done dominates
        run_one("R4 ras wait", 16'd1, 32'd100, 16'd2, 32'd120, 32'd150, 32'd0, 32'd11, 32'd13, 32'd14);
        // R4 miss, busy dominates
        run_one("R4 busy wait", 16'd1, 32'd100, 16'd2, 32'd180, 32'd150, 32'd0, 32'd11, 32'd13, 32'd14);
        // R6 miss, activate stall: cand = 100+0+11 = 111 < 140
        run_one("R6 act stall", 16'd1, 32'd100, 16'd2, 32'd50, 32'd60, 32'd140, 32'd11, 32'd13, 32'd14);
        // R6 cand exactly at activate bound: no stall
        run_one("R6 act edge", 16'd1, 32'd100, 16'd2, 32'd50, 32'd60, 32'd111, 32'd11, 32'd13, 32'd14);
        // R5 R6 no open row: cand = 100, bound 105 -> stall 5
        run_one("R5 R6 closed", 16'd3, 32'd100, NONE, 32'd90, 32'd95, 32'd105, 32'd11, 32'd13, 32'd14);
        // R7 miss with everything in the past
        run_one("R7 plain miss", 16'd3, 32'd1000, 16'd4, 32'd10, 32'd20, 32'd30, 32'd11, 32'd13, 32'd14);

        // random mix
        for (int i = 0; i < 300; i++) begin
            logic [RW-1:0] orow, rr;
            logic [TW-1:0] arr;
            orow = ($urandom % 4 == 0) ? NONE : RW'($urandom % 4);
            rr   = RW'($urandom % 4);
            arr  = 32'd1000 + ($urandom % 1000);
            run_one("R2 R3 R4 R6 R7 random", rr, arr, orow,
                    32'd800 + ($urandom % 600), 32'd800 + ($urandom % 600),
                    32'd800 + ($urandom % 800),
                    1 + ($urandom % 40), 1 + ($urandom % 40), 1 + ($urandom % 40));
        end

        // back-to-back requests keep out_valid high (R8)
        @(negedge clk);
        in_req_row = 16'd7; in_open_row = 16'd7; in_arrival = 32'd50; in_busy_until = 32'd0;
        in_t_cl = 32'd9; in_valid = 1'b1;
        @(negedge clk);
        chk("R8 b2b first", out_valid, 1);
        in_t_cl = 32'd21;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 b2b second", out_valid, 1);
        chk("R3 b2b value", out_total_lat, 21);
        @(negedge clk);
        chk("R8 b2b end", out_valid, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule